// File: doc/BRIEF.md
# Tear-Check Read Pointer Tracker

This block models where a command-mode panel is in its own refresh scan, so that a new frame is pushed only when the push cannot overtake the scan. A line counter, the read pointer, advances once per line period. The line period is a programmable number of clock cycles. The counter restarts from a programmable initial line whenever a vsync occurs. A vsync comes either from a rising edge on the panel's tearing-effect (TE) pin or from the counter reaching the programmed frame height. Every restart also advances a frame counter.

Frame write requests arrive from the display pipeline, or from an internal auto-refresh timer that requests a frame every N vsyncs. A request is held pending until the read pointer lies within a start distance of a programmed start line. The write then counts as active only while the pointer stays within a wider continue distance. Two line-match interrupts are available: one on the read pointer alone, and one that fires only during an active write.

Software configures the block through a simple word-addressed register port. A read returns its data one cycle after the address is presented.

Top module: `te_rdptr_tracker`

## Requirements
- R1: After a synchronous reset, every output is 0 and every register address reads back 0.
- R2: The writable words sit at these addresses: 0 control (bit 0 enables checking), 1 sync setup, 2 frame height, 3 initial line, 4 start line, 5 distances (continue distance in bits 31:16, start distance in bits 15:0), 6 interrupt lines (write line in bits 31:16, read line in bits 15:0), 7 auto-refresh. Words 0, 1, 5, 6 and 7 read back all 32 bits as written, and words 2 to 4 read back their low 16 bits. The read data appears one cycle after the read address.
- R3: In sync setup, bits 15:0 give the clocks per line (0 or 1 means one clock) and bit 19 enables counting. While counting, the line advances by one per line period. After line height-1 it returns to the initial line and the frame count advances. Address 8 reads the frame count in bits 31:16 and the line in bits 15:0.
- R4: With sync setup bit 20 set, each rising edge on `te_in` (after a two-flop synchronizer) reloads the initial line and advances the frame count. With bit 20 clear, `te_in` has no effect.
- R5: While bit 19 is clear, the line holds the initial value, the frame count holds, and no interrupt fires.
- R6: `rd_irq_o` pulses for one cycle each time the line register takes the value of the read interrupt line.
- R7: With checking on, a pending request starts a write (`wr_start_o` pulses, `wr_active_o` rises) only while counting is enabled and |line − start line| ≤ start distance.
- R8: With checking on, an active write ends when |line − start line| exceeds the continue distance or counting stops.
- R9: `wr_irq_o` pulses when the line takes the value of the write interrupt line while a write is active, and never otherwise.
- R10: With checking off, a pending request starts a write on the next cycle whatever the line, and the write is active for that one cycle only.
- R11: In the auto-refresh word, bit 31 enables and bits 15:0 give N (0 disables). Every N-th vsync raises a request. Writing the word restarts the vsync count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read address |
| reg_rd_data | output | 32 | Registered read data |
| te_in | input | 1 | Asynchronous tearing-effect input from the panel |
| frame_req_i | input | 1 | Single-cycle frame write request |
| wr_start_o | output | 1 | Pulse: frame write may begin |
| wr_active_o | output | 1 | Frame write is inside its permitted window |
| rd_irq_o | output | 1 | Read-pointer line interrupt pulse |
| wr_irq_o | output | 1 | Write-pointer line interrupt pulse |

## Verification
The bench builds the tracker with its default two-stage TE synchronizer and 16-bit fields. It then programs small geometries, such as a height of 10 lines at 1 or 3 clocks per line, so that many wraps, frame counts and auto-refresh intervals occur within a few hundred cycles. A large height of 200 keeps internal wraps out of the way while TE pulses are applied. This separates the external and internal vsync sources. A behavioural model runs alongside and is compared every cycle, and pulse counts over fixed windows are checked against values derived from the frame period.

// File: rtl/te_pkg.sv
`timescale 1ns/1ps
package te_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SYNC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_HEIGHT = 4'd2;
  localparam logic [ADDR_W-1:0] A_INIT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_START  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DIST   = 4'd5;
  localparam logic [ADDR_W-1:0] A_IRQLN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_AUTO   = 4'd7;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd8;

  localparam int SYNC_EN_BIT  = 19;
  localparam int SYNC_EXT_BIT = 20;
  localparam int AUTO_EN_BIT  = 31;

  typedef struct packed {
    logic               chk_en;
    logic               cnt_en;
    logic               ext_sel;
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] height;
    logic [FIELD_W-1:0] init;
    logic [FIELD_W-1:0] start_line;
    logic [FIELD_W-1:0] start_dist;
    logic [FIELD_W-1:0] cont_dist;
    logic [FIELD_W-1:0] rd_line;
    logic [FIELD_W-1:0] wr_line;
    logic               auto_en;
    logic [FIELD_W-1:0] auto_n;
  } te_cfg_t;

  function automatic logic [FIELD_W-1:0] line_dist(input logic [FIELD_W-1:0] a,
                                                   input logic [FIELD_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/te_regs.sv
`timescale 1ns/1ps
module te_regs
  import te_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rd_data,
  output te_cfg_t           cfg,
  output logic              auto_clr
);
  logic [DATA_W-1:0]  ctrl_q, sync_q, dist_q, irqln_q, auto_q;
  logic [FIELD_W-1:0] height_q, init_q, start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      sync_q   <= '0;
      dist_q   <= '0;
      irqln_q  <= '0;
      auto_q   <= '0;
      height_q <= '0;
      init_q   <= '0;
      start_q  <= '0;
      auto_clr <= 1'b0;
    end else begin
      auto_clr <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:   ctrl_q   <= wr_data;
          A_SYNC:   sync_q   <= wr_data;
          A_HEIGHT: height_q <= wr_data[FIELD_W-1:0];
          A_INIT:   init_q   <= wr_data[FIELD_W-1:0];
          A_START:  start_q  <= wr_data[FIELD_W-1:0];
          A_DIST:   dist_q   <= wr_data;
          A_IRQLN:  irqln_q  <= wr_data;
          A_AUTO: begin
            auto_q   <= wr_data;
            auto_clr <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:   rd_data <= ctrl_q;
        A_SYNC:   rd_data <= sync_q;
        A_HEIGHT: rd_data <= DATA_W'(height_q);
        A_INIT:   rd_data <= DATA_W'(init_q);
        A_START:  rd_data <= DATA_W'(start_q);
        A_DIST:   rd_data <= dist_q;
        A_IRQLN:  rd_data <= irqln_q;
        A_AUTO:   rd_data <= auto_q;
        A_STATUS: rd_data <= status;
        default:  rd_data <= '0;
      endcase
    end
  end

  always_comb begin
    cfg.chk_en     = ctrl_q[0];
    cfg.cnt_en     = sync_q[SYNC_EN_BIT];
    cfg.ext_sel    = sync_q[SYNC_EXT_BIT];
    cfg.div        = sync_q[FIELD_W-1:0];
    cfg.height     = height_q;
    cfg.init       = init_q;
    cfg.start_line = start_q;
    cfg.start_dist = dist_q[FIELD_W-1:0];
    cfg.cont_dist  = dist_q[DATA_W-1:FIELD_W];
    cfg.rd_line    = irqln_q[FIELD_W-1:0];
    cfg.wr_line    = irqln_q[DATA_W-1:FIELD_W];
    cfg.auto_en    = auto_q[AUTO_EN_BIT];
    cfg.auto_n     = auto_q[FIELD_W-1:0];
  end
endmodule

// File: rtl/te_line_counter.sv
`timescale 1ns/1ps
module te_line_counter
  import te_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               te_in,
  input  te_cfg_t            cfg,
  output logic [FIELD_W-1:0] line,
  output logic [FIELD_W-1:0] frame,
  output logic               vsync,
  output logic               line_upd,
  output logic [FIELD_W-1:0] next_line,
  output logic               rd_irq
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0]    te_sr;
  logic [FIELD_W-1:0] div_cnt;
  logic               te_edge, div_last, tick, wrap;

  generate
    genvar gi;
    for (gi = 0; gi < SR_W; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) te_sr[0] <= 1'b0;
          else     te_sr[0] <= te_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) te_sr[gi] <= 1'b0;
          else     te_sr[gi] <= te_sr[gi-1];
        end
      end
    end
  endgenerate

  assign te_edge   = te_sr[SYNC_STAGES-1] & ~te_sr[SYNC_STAGES];
  assign div_last  = (cfg.div <= FIELD_W'(1)) || (div_cnt == cfg.div - FIELD_W'(1));
  assign tick      = cfg.cnt_en & div_last;
  assign wrap      = tick & (line == cfg.height - FIELD_W'(1));
  assign vsync     = cfg.cnt_en & ((cfg.ext_sel & te_edge) | wrap);
  assign line_upd  = vsync | tick;
  assign next_line = vsync ? cfg.init : line + FIELD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      line    <= '0;
      frame   <= '0;
      div_cnt <= '0;
    end else if (!cfg.cnt_en) begin
      line    <= cfg.init;
      div_cnt <= '0;
    end else if (vsync) begin
      line    <= next_line;
      frame   <= frame + FIELD_W'(1);
      div_cnt <= '0;
    end else if (tick) begin
      line    <= next_line;
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + FIELD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_irq <= 1'b0;
    else     rd_irq <= line_upd && (next_line == cfg.rd_line);
  end
endmodule

// File: rtl/te_write_gate.sv
`timescale 1ns/1ps
module te_write_gate
  import te_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  te_cfg_t            cfg,
  input  logic [FIELD_W-1:0] line,
  input  logic               vsync,
  input  logic               line_upd,
  input  logic [FIELD_W-1:0] next_line,
  input  logic               frame_req,
  input  logic               auto_clr,
  output logic               wr_start,
  output logic               wr_active,
  output logic               wr_irq
);
  logic [FIELD_W-1:0] auto_cnt;
  logic               pending, in_start, in_cont, auto_hit, req, go;

  assign in_start = line_dist(line, cfg.start_line) <= cfg.start_dist;
  assign in_cont  = line_dist(line, cfg.start_line) <= cfg.cont_dist;
  assign auto_hit = vsync & cfg.auto_en & (cfg.auto_n != '0) &
                    (auto_cnt == cfg.auto_n - FIELD_W'(1));
  assign req      = frame_req | auto_hit;
  assign go       = pending & ~wr_active & (~cfg.chk_en | (cfg.cnt_en & in_start));

  always_ff @(posedge clk) begin
    if (rst || auto_clr || !cfg.auto_en) begin
      auto_cnt <= '0;
    end else if (vsync && cfg.auto_n != '0) begin
      auto_cnt <= auto_hit ? '0 : auto_cnt + FIELD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      wr_active <= 1'b0;
      wr_start  <= 1'b0;
      wr_irq    <= 1'b0;
    end else begin
      pending  <= go ? req : (pending | req);
      wr_start <= go;
      wr_irq   <= line_upd && (next_line == cfg.wr_line) && wr_active;
      if (!cfg.chk_en)
        wr_active <= go;
      else if (go)
        wr_active <= 1'b1;
      else if (wr_active && (!cfg.cnt_en || !in_cont))
        wr_active <= 1'b0;
    end
  end
endmodule

// File: rtl/te_rdptr_tracker.sv
`timescale 1ns/1ps
module te_rdptr_tracker
  import te_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              te_in,
  input  logic              frame_req_i,
  output logic              wr_start_o,
  output logic              wr_active_o,
  output logic              rd_irq_o,
  output logic              wr_irq_o
);
  te_cfg_t            cfg;
  logic               auto_clr, vsync, line_upd, cnt_en;
  logic [FIELD_W-1:0] line, frame, next_line;

  assign cnt_en = cfg.cnt_en;

  te_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .status({frame, line}),
    .rd_data(reg_rd_data), .cfg(cfg), .auto_clr(auto_clr)
  );

  te_line_counter #(.SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .clk(clk), .rst(rst), .te_in(te_in), .cfg(cfg),
    .line(line), .frame(frame), .vsync(vsync),
    .line_upd(line_upd), .next_line(next_line), .rd_irq(rd_irq_o)
  );

  te_write_gate u_gate (
    .clk(clk), .rst(rst), .cfg(cfg), .line(line), .vsync(vsync),
    .line_upd(line_upd), .next_line(next_line), .frame_req(frame_req_i),
    .auto_clr(auto_clr), .wr_start(wr_start_o), .wr_active(wr_active_o),
    .wr_irq(wr_irq_o)
  );
endmodule

// File: rtl/te_rdptr_checker.sv
`timescale 1ns/1ps
module te_rdptr_checker (
  input logic clk,
  input logic rst,
  input logic wr_start,
  input logic wr_active,
  input logic rd_irq,
  input logic wr_irq,
  input logic cnt_en
);
  assert_start_sets_active_R7: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> wr_active);
  assert_no_double_start_R10: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !wr_start);
  assert_rdirq_needs_count_R5: assert property (@(posedge clk) disable iff (rst)
    rd_irq |-> $past(cnt_en));
  assert_wrirq_needs_active_R9: assert property (@(posedge clk) disable iff (rst)
    wr_irq |-> $past(wr_active));
endmodule

bind te_rdptr_tracker te_rdptr_checker u_chk (
  .clk(clk), .rst(rst), .wr_start(wr_start_o), .wr_active(wr_active_o),
  .rd_irq(rd_irq_o), .wr_irq(wr_irq_o), .cnt_en(cnt_en)
);

// File: tb/te_rdptr_tracker_test.sv
`timescale 1ns/1ps
module te_rdptr_tracker_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr_en = 1'b0, te_in = 1'b0, frame_req_i = 1'b0;
  logic [3:0]  reg_wr_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic        wr_start_o, wr_active_o, rd_irq_o, wr_irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  te_rdptr_tracker uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .te_in(te_in), .frame_req_i(frame_req_i), .wr_start_o(wr_start_o),
    .wr_active_o(wr_active_o), .rd_irq_o(rd_irq_o), .wr_irq_o(wr_irq_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] r_ctrl, r_sync, r_dist, r_irq, r_auto, m_rdata;
  logic [15:0] r_h, r_init, r_start, m_line, m_frame, m_div, m_ar;
  logic        s0, s1, s2, m_pend, m_act, m_start, m_rirq, m_wirq;

  function automatic logic [15:0] dist16(input logic [15:0] a, input logic [15:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {r_ctrl, r_sync, r_dist, r_irq, r_auto, m_rdata} = '0;
      {r_h, r_init, r_start, m_line, m_frame, m_div, m_ar} = '0;
      {s0, s1, s2, m_pend, m_act, m_start, m_rirq, m_wirq} = '0;
    end else begin
      logic en, chk, tk, vs, upd, hit, go, ins, inc;
      logic [15:0] dv, nl;
      logic [31:0] rd;
      en  = r_sync[19];
      chk = r_ctrl[0];
      dv  = r_sync[15:0];
      tk  = en && ((dv <= 16'd1) || (m_div == dv - 16'd1));
      vs  = en && ((r_sync[20] && s1 && !s2) || (tk && m_line == r_h - 16'd1));
      upd = vs || tk;
      nl  = vs ? r_init : m_line + 16'd1;
      ins = dist16(m_line, r_start) <= r_dist[15:0];
      inc = dist16(m_line, r_start) <= r_dist[31:16];
      hit = vs && r_auto[31] && r_auto[15:0] != 0 && m_ar == r_auto[15:0] - 16'd1;
      go  = m_pend && !m_act && (!chk || (en && ins));
      case (reg_rd_addr)
        4'd0: rd = r_ctrl;           4'd1: rd = r_sync;
        4'd2: rd = {16'd0, r_h};     4'd3: rd = {16'd0, r_init};
        4'd4: rd = {16'd0, r_start}; 4'd5: rd = r_dist;
        4'd6: rd = r_irq;            4'd7: rd = r_auto;
        4'd8: rd = {m_frame, m_line};
        default: rd = 0;
      endcase
      m_rdata = rd;
      m_rirq  = upd && nl == r_irq[15:0];
      m_wirq  = upd && nl == r_irq[31:16] && m_act;
      m_start = go;
      m_pend  = go ? (frame_req_i || hit) : (m_pend || frame_req_i || hit);
      if (!chk) m_act = go;
      else if (go) m_act = 1;
      else if (m_act && (!en || !inc)) m_act = 0;
      if (!r_auto[31]) m_ar = 0;
      else if (vs && r_auto[15:0] != 0) m_ar = hit ? 16'd0 : m_ar + 16'd1;
      if (!en) begin m_line = r_init; m_div = 0; end
      else if (vs) begin m_line = nl; m_frame = m_frame + 16'd1; m_div = 0; end
      else if (tk) begin m_line = nl; m_div = 0; end
      else m_div = m_div + 16'd1;
      s2 = s1; s1 = s0; s0 = te_in;
      if (reg_wr_en) begin
        case (reg_wr_addr)
          4'd0: r_ctrl = reg_wr_data;        4'd1: r_sync = reg_wr_data;
          4'd2: r_h = reg_wr_data[15:0];     4'd3: r_init = reg_wr_data[15:0];
          4'd4: r_start = reg_wr_data[15:0]; 4'd5: r_dist = reg_wr_data;
          4'd6: r_irq = reg_wr_data;
          4'd7: begin r_auto = reg_wr_data; m_ar = 0; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 5;
      if (rd_irq_o !== m_rirq) begin errors++; $display("FAIL R6 rd_irq act=%0b exp=%0b t=%0t", rd_irq_o, m_rirq, $time); end
      if (wr_irq_o !== m_wirq) begin errors++; $display("FAIL R9 wr_irq act=%0b exp=%0b t=%0t", wr_irq_o, m_wirq, $time); end
      if (wr_start_o !== m_start) begin errors++; $display("FAIL R7 wr_start act=%0b exp=%0b t=%0t", wr_start_o, m_start, $time); end
      if (wr_active_o !== m_act) begin errors++; $display("FAIL R8 wr_active act=%0b exp=%0b t=%0t", wr_active_o, m_act, $time); end
      if (reg_rd_data !== m_rdata) begin errors++; $display("FAIL R3 rd_data act=%h exp=%h t=%0t", reg_rd_data, m_rdata, $time); end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_addr = a;
    @(negedge clk); d = reg_rd_data;
  endtask

  task automatic count(input int n, output int nrd, output int nwr, output int nst);
    nrd = 0; nwr = 0; nst = 0;
    repeat (n) begin
      @(negedge clk);
      nrd += int'(rd_irq_o); nwr += int'(wr_irq_o); nst += int'(wr_start_o);
    end
  endtask

  task automatic pulse_req;
    @(negedge clk); frame_req_i = 1;
    @(negedge clk); frame_req_i = 0;
  endtask

  task automatic te_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); te_in = 1;
      repeat (3) @(negedge clk);
      te_in = 0;
      repeat (16) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, d2;
    int nrd, nwr, nst;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 wr_start", wr_start_o, 0);
    check("R1 wr_active", wr_active_o, 0);
    check("R1 irqs", rd_irq_o | wr_irq_o, 0);
    for (int a = 0; a < 9; a++) begin
      rd_reg(4'(a), d);
      check("R1 readback", d, 0);
    end
    // R2: configuration and readback
    wr_reg(4'd2, 32'd10);
    wr_reg(4'd3, 32'd2);
    wr_reg(4'd4, 32'd6);
    wr_reg(4'd5, 32'h0003_0001);
    wr_reg(4'd6, 32'h0008_0004);
    wr_reg(4'd0, 32'h0000_0001);
    wr_reg(4'd1, 32'h0010_0003);
    rd_reg(4'd1, d); check("R2 sync word", d, 32'h0010_0003);
    rd_reg(4'd2, d); check("R2 height", d, 10);
    rd_reg(4'd5, d); check("R2 distances", d, 32'h0003_0001);
    rd_reg(4'd6, d); check("R2 irq lines", d, 32'h0008_0004);
    rd_reg(4'd8, d); check("R5 line held at init", d[15:0], 2);
    // R3/R6: internal counting, 3 clocks per line, 8 lines per frame = 24 cycles
    wr_reg(4'd1, 32'h0008_0003);
    count(240, nrd, nwr, nst);
    check("R6 rd irq per frame", nrd, 10);
    check("R9 no wr irq without write", nwr, 0);
    rd_reg(4'd8, d);
    repeat (22) @(negedge clk);
    rd_reg(4'd8, d2);
    check("R3 line after one frame", d2[15:0], d[15:0]);
    check("R3 frame advance", 16'(d2[31:16] - d[31:16]), 1);
    // R7/R8/R9: gated write
    pulse_req();
    count(48, nrd, nwr, nst);
    check("R7 one start", nst, 1);
    check("R9 wr irq during write", nwr, 1);
    check("R8 write ended", wr_active_o, 0);
    // R10: checking off
    wr_reg(4'd0, 32'h0);
    repeat (4) @(negedge clk);
    pulse_req();
    @(negedge clk);
    check("R10 immediate start", wr_start_o, 1);
    @(negedge clk);
    check("R10 single-cycle active", wr_active_o, 0);
    // R4: external TE
    wr_reg(4'd2, 32'd200);
    wr_reg(4'd3, 32'd5);
    wr_reg(4'd6, 32'h0008_0005);
    wr_reg(4'd1, 32'h0000_0001);
    wr_reg(4'd1, 32'h0018_0001);
    fork
      te_pulses(3);
      count(70, nrd, nwr, nst);
    join
    check("R4 TE reloads", nrd, 3);
    wr_reg(4'd1, 32'h0008_0001);
    fork
      te_pulses(3);
      count(70, nrd, nwr, nst);
    join
    check("R4 TE ignored internal", nrd, 0);
    // R5: counting disabled
    wr_reg(4'd1, 32'h0);
    count(50, nrd, nwr, nst);
    check("R5 no irq", nrd + nwr, 0);
    rd_reg(4'd8, d);
    repeat (30) @(negedge clk);
    rd_reg(4'd8, d2);
    check("R5 line at init", d2[15:0], 5);
    check("R5 status frozen", d2, d);
    // R11: auto-refresh every 3 vsyncs, 8-cycle frames
    wr_reg(4'd2, 32'd10);
    wr_reg(4'd3, 32'd2);
    wr_reg(4'd1, 32'h0008_0001);
    wr_reg(4'd7, 32'h8000_0003);
    count(240, nrd, nwr, nst);
    check("R11 refresh low bound", nst >= 9, 1);
    check("R11 refresh high bound", nst <= 11, 1);
    wr_reg(4'd7, 32'h0);
    count(60, nrd, nwr, nst);
    check("R11 refresh off", nst, 0);
    finish_run();
  end
endmodule